// File: doc/BRIEF.md
# Tiered State-Enable Register File

This block keeps the enable bits that decide whether less privileged software may touch optional pieces of processor state. It has three tiers of four registers each: a machine tier, a hypervisor tier and a supervisor tier. A higher tier gates the tier below it. If a bit is zero in the machine tier, the same bit is forced to zero in the hypervisor and supervisor tiers. When the hart runs a guest, a zero in the hypervisor tier also hides the matching supervisor bit.

Software reaches the registers through a plain CSR port. The port has a 12-bit address, a combinational read and a write strobe. The `XLEN` parameter sets a 32-bit or a 64-bit port width. With a 32-bit port, the upper half of each machine and hypervisor register sits at its own address. Feature inputs tell the block which controlled features exist, and only those bits can be written. The block drives out the effective enable vectors of all three tiers so that access checks elsewhere in the core can use them.

Top module: `stateen_csr_file`

## Requirements
- R1: The machine tier decodes at 0x30C..0x30F, the hypervisor tier at 0x60C..0x60F and the supervisor tier at 0x10C..0x10F. Address bits [1:0] select register 0..3. A read returns the effective value of the selected register in the same cycle.
- R2: With XLEN=32, a lower address reaches bits 31:0. The addresses 0x31C..0x31F (machine) and 0x61C..0x61F (hypervisor) reach bits 63:32 of register 0..3. With XLEN=64, a lower address reaches all 64 bits.
- R3: In the supervisor tier, bits 63:32 always read zero. Only bits 0 and 1 of supervisor register 0 can ever hold a one.
- R4: After reset, every register of every tier reads zero.
- R5: In register 0 of the machine and hypervisor tiers, four bits are writable. Bit 0 is writable when feat_query=1, and bit 1 when feat_xfp=1 and f_present=0. Bit 62 is writable when feat_tcmp=1, and bit 63 always. Every other bit, in every register, reads zero and ignores writes.
- R6: If a machine-tier bit is zero, the same bit reads zero in the hypervisor and supervisor registers of the same index. Writes to that bit in those registers are ignored.
- R7: Clearing a machine-tier bit also clears the stored lower-tier bits. Setting the machine bit again does not bring back an old lower-tier value.
- R8: While f_present=1, bit 1 reads zero in all tiers. It stays zero after f_present falls, until it is written again.
- R9: While virt_mode=1, each supervisor bit also reads zero where the same hypervisor bit is zero. Supervisor writes are masked in the same way. While virt_mode=0, the hypervisor tier has no effect on the supervisor tier.
- R10: csr_illegal=1 for an access (csr_en=1) to an address inside the decoded ranges that does not exist for the current XLEN: the upper-half addresses when XLEN=64. Such an access reads zero and changes no state. Addresses outside the ranges give csr_illegal=0.
- R11: m_eff, h_eff and s_eff carry the effective values of registers 0..3, with register i in bits 64*i+63:64*i. s_eff applies the masking that matches the present virt_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_en | input | 1 | CSR access valid |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data (combinational) |
| csr_illegal | output | 1 | In-range address not implemented |
| virt_mode | input | 1 | Hart runs inside a virtual machine |
| feat_query | input | 1 | Query-data feature exists |
| feat_xfp | input | 1 | FP-in-integer-registers feature exists |
| f_present | input | 1 | Separate FP register file exists |
| feat_tcmp | input | 1 | Supervisor timer compare exists |
| m_eff | output | 256 | Effective machine enables, registers 0..3 |
| h_eff | output | 256 | Effective hypervisor enables, registers 0..3 |
| s_eff | output | 256 | Effective supervisor enables, registers 0..3 |

## Verification
The bench clears a machine bit and then sets it again. A design that only masks on read would then show the old hypervisor and supervisor contents, and the bench would see them. It toggles the guest input while the hypervisor copy of a bit is cleared. A design that ignores the guest mode, or that applies it all the time, returns the wrong supervisor value in one of the two phases. It raises and drops the FP-register-file input, and it writes all ones to reserved and missing-feature positions; a loose write mask shows up there as stray ones. It also accesses upper-half addresses on both port widths, which catches a design that lets a 64-bit port alias them or that puts half-writes in the wrong half.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
    localparam int NREG      = 4;
    localparam int BIT_QUERY = 0;
    localparam int BIT_XFP   = 1;
    localparam int BIT_TCMP  = 62;
    localparam int BIT_SACC  = 63;

    typedef logic [63:0] word_t;

    typedef enum logic [1:0] {
        TIER_NONE = 2'd0,
        TIER_MACH = 2'd1,
        TIER_HYP  = 2'd2,
        TIER_SUP  = 2'd3
    } tier_e;

    typedef struct packed {
        tier_e      tier;
        logic       upper;
        logic [1:0] idx;
        logic       in_range;
        logic       legal;
    } dec_t;
endpackage

// File: rtl/stateen_addr_dec.sv
module stateen_addr_dec
    import stateen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [11:0] addr,
    output dec_t        dec
);
    localparam logic WIDE = (XLEN == 64);

    always_comb begin
        dec          = '0;
        dec.tier     = TIER_NONE;
        dec.idx      = addr[1:0];
        dec.in_range = 1'b1;
        unique case (addr[11:2])
            10'h0C3: dec.tier = TIER_MACH;
            10'h0C7: begin dec.tier = TIER_MACH; dec.upper = 1'b1; end
            10'h183: dec.tier = TIER_HYP;
            10'h187: begin dec.tier = TIER_HYP; dec.upper = 1'b1; end
            10'h043: dec.tier = TIER_SUP;
            default: dec.in_range = 1'b0;
        endcase
        dec.legal = dec.in_range && !(dec.upper && WIDE);
    end
endmodule

// File: rtl/stateen_wmask.sv
module stateen_wmask
    import stateen_pkg::*;
(
    input  logic  feat_query,
    input  logic  feat_xfp,
    input  logic  f_present,
    input  logic  feat_tcmp,
    output word_t wm_upper [NREG],
    output word_t wm_sup   [NREG]
);
    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            if (gi == 0) begin : g_defined
                always_comb begin
                    wm_upper[gi]           = '0;
                    wm_upper[gi][BIT_QUERY] = feat_query;
                    wm_upper[gi][BIT_XFP]   = feat_xfp & ~f_present;
                    wm_upper[gi][BIT_TCMP]  = feat_tcmp;
                    wm_upper[gi][BIT_SACC]  = 1'b1;
                    wm_sup[gi]             = {32'h0, wm_upper[gi][31:0]};
                end
            end else begin : g_reserved
                assign wm_upper[gi] = '0;
                assign wm_sup[gi]   = '0;
            end
        end
    endgenerate
endmodule

// File: rtl/stateen_csr_file.sv
module stateen_csr_file
    import stateen_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_en,
    input  logic                csr_we,
    input  logic [11:0]         csr_addr,
    input  logic [XLEN-1:0]     csr_wdata,
    output logic [XLEN-1:0]     csr_rdata,
    output logic                csr_illegal,
    input  logic                virt_mode,
    input  logic                feat_query,
    input  logic                feat_xfp,
    input  logic                f_present,
    input  logic                feat_tcmp,
    output logic [NREG*64-1:0]  m_eff,
    output logic [NREG*64-1:0]  h_eff,
    output logic [NREG*64-1:0]  s_eff
);
    localparam int VW = NREG * 64;

    typedef struct packed {
        word_t [NREG-1:0] m;
        word_t [NREG-1:0] h;
        word_t [NREG-1:0] s;
    } state_t;

    state_t st_d, st_q;
    dec_t   dec;
    word_t  wm_upper [NREG];
    word_t  wm_sup   [NREG];
    word_t  m_v [NREG];
    word_t  h_v [NREG];
    word_t  s_v [NREG];
    word_t  wd64, hmask, cur, newv, rd64;

    stateen_addr_dec #(.XLEN(XLEN)) u_dec (
        .addr (csr_addr),
        .dec  (dec)
    );

    stateen_wmask u_wmask (
        .feat_query (feat_query),
        .feat_xfp   (feat_xfp),
        .f_present  (f_present),
        .feat_tcmp  (feat_tcmp),
        .wm_upper   (wm_upper),
        .wm_sup     (wm_sup)
    );

    generate
        if (XLEN == 64) begin : g_wide
            assign wd64      = csr_wdata;
            assign hmask     = '1;
            assign csr_rdata = rd64;
        end else begin : g_narrow
            assign wd64      = {csr_wdata, csr_wdata};
            assign hmask     = dec.upper ? {32'hFFFF_FFFF, 32'h0} : {32'h0, 32'hFFFF_FFFF};
            assign csr_rdata = dec.upper ? rd64[63:32] : rd64[31:0];
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_eff
            assign m_v[gi] = st_q.m[gi] & wm_upper[gi];
            assign h_v[gi] = st_q.h[gi] & m_v[gi];
            assign s_v[gi] = st_q.s[gi] & wm_sup[gi] & m_v[gi] & (virt_mode ? h_v[gi] : '1);
            assign m_eff[gi*64 +: 64] = m_v[gi];
            assign h_eff[gi*64 +: 64] = h_v[gi];
            assign s_eff[gi*64 +: 64] = s_v[gi];
        end
    endgenerate

    assign csr_illegal = csr_en && dec.in_range && !dec.legal;

    always_comb begin
        cur  = '0;
        rd64 = '0;
        unique case (dec.tier)
            TIER_MACH: begin cur = st_q.m[dec.idx]; rd64 = m_v[dec.idx]; end
            TIER_HYP:  begin cur = st_q.h[dec.idx]; rd64 = h_v[dec.idx]; end
            TIER_SUP:  begin cur = st_q.s[dec.idx]; rd64 = s_v[dec.idx]; end
            default:   begin cur = '0; rd64 = '0; end
        endcase
        if (!dec.legal) rd64 = '0;
        newv = (cur & ~hmask) | (wd64 & hmask);

        st_d = st_q;
        if (csr_en && csr_we && dec.legal) begin
            unique case (dec.tier)
                TIER_MACH: st_d.m[dec.idx] = newv;
                TIER_HYP:  st_d.h[dec.idx] = newv & m_v[dec.idx];
                TIER_SUP:  st_d.s[dec.idx] = newv & m_v[dec.idx]
                                             & (virt_mode ? h_v[dec.idx] : '1);
                default: ;
            endcase
        end
        for (int i = 0; i < NREG; i++) begin
            st_d.m[i] = st_d.m[i] & wm_upper[i];
            st_d.h[i] = st_d.h[i] & st_d.m[i];
            st_d.s[i] = st_d.s[i] & st_d.m[i] & wm_sup[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Stored hypervisor bits never outlive the machine bit (R6, R7)
    p_hyp_within_mach_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.h & ~st_q.m) == '0);

    // Stored supervisor bits never outlive the machine bit (R6)
    p_sup_within_mach_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.s & ~st_q.m) == '0);

    // Supervisor upper half never holds a one (R3)
    p_sup_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s[0][63:32] == 32'h0 && st_q.s[1][63:32] == 32'h0 &&
        st_q.s[2][63:32] == 32'h0 && st_q.s[3][63:32] == 32'h0);

    // Reserved positions and registers 1..3 stay zero (R5)
    p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.m[0][2] && !st_q.m[0][61] && st_q.m[1] == '0 &&
        st_q.m[2] == '0 && st_q.m[3] == '0);

    // A separate FP register file forces bit 1 clear in the next state (R8)
    p_fp_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        f_present |=> !st_q.m[0][BIT_XFP]);

    // Unimplemented in-range address reads zero and leaves state alone (R10)
    p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == '0);
    p_illegal_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_illegal && $stable(f_present) && $stable(feat_query) &&
         $stable(feat_xfp) && $stable(feat_tcmp)) |=> $stable(st_q));
endmodule

// File: tb/stateen_csr_file_tb.sv
`timescale 1ns/1ps
module stateen_csr_file_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        csr_en = 0, csr_we = 0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] rdata;
    logic [31:0] rdata32;
    logic        illegal, illegal32;
    logic        virt_mode = 0, feat_query = 1, feat_xfp = 1, f_present = 0, feat_tcmp = 1;
    logic [255:0] m_eff, h_eff, s_eff, m32, h32, s32;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    stateen_csr_file #(.XLEN(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(rdata),
        .csr_illegal(illegal), .virt_mode(virt_mode), .feat_query(feat_query),
        .feat_xfp(feat_xfp), .f_present(f_present), .feat_tcmp(feat_tcmp),
        .m_eff(m_eff), .h_eff(h_eff), .s_eff(s_eff));

    stateen_csr_file #(.XLEN(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata[31:0]), .csr_rdata(rdata32),
        .csr_illegal(illegal32), .virt_mode(virt_mode), .feat_query(feat_query),
        .feat_xfp(feat_xfp), .f_present(f_present), .feat_tcmp(feat_tcmp),
        .m_eff(m32), .h_eff(h32), .s_eff(s32));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_en = 0; csr_we = 0;
    endtask

    task automatic rd(input logic [11:0] a);
        @(negedge clk);
        csr_en = 1; csr_we = 0; csr_addr = a;
        #1;
    endtask

    localparam logic [63:0] ALL4 = 64'hC000_0000_0000_0003;

    task automatic t_reset;
        rd(12'h30C); check("R4 mach", rdata, 0);
        rd(12'h60C); check("R4 hyp", rdata, 0);
        rd(12'h10C); check("R4 sup", rdata, 0);
        check("R4 m_eff", m_eff[63:0], 0);
    endtask

    task automatic t_map_and_mask;
        wr(12'h30C, '1); rd(12'h30C); check("R5 mach0", rdata, ALL4);
        wr(12'h30D, '1); rd(12'h30D); check("R5 mach1 reserved", rdata, 0);
        wr(12'h60C, '1); rd(12'h60C); check("R1 hyp0", rdata, ALL4);
        wr(12'h10C, '1); rd(12'h10C); check("R3 sup0", rdata, 64'h3);
        check("R11 m_eff", m_eff[63:0], ALL4);
        check("R11 h_eff", h_eff[63:0], ALL4);
    endtask

    task automatic t_chain;
        wr(12'h30C, 64'h8000_0000_0000_0001);
        rd(12'h60C); check("R6 hyp masked", rdata, 64'h8000_0000_0000_0001);
        rd(12'h10C); check("R6 sup masked", rdata, 64'h1);
        wr(12'h60C, '1); rd(12'h60C); check("R6 hyp write blocked", rdata, 64'h8000_0000_0000_0001);
        wr(12'h30C, '1);
        rd(12'h60C); check("R7 hyp no stale", rdata, 64'h8000_0000_0000_0001);
        rd(12'h10C); check("R7 sup no stale", rdata, 64'h1);
    endtask

    task automatic t_virt;
        wr(12'h10C, '1); rd(12'h10C); check("R9 sup native", rdata, 64'h3);
        @(negedge clk); virt_mode = 1;
        rd(12'h10C); check("R9 sup guest view", rdata, 64'h1);
        check("R11 s_eff guest", s_eff[63:0], 64'h1);
        @(negedge clk); virt_mode = 0;
        rd(12'h10C); check("R9 sup native again", rdata, 64'h3);
    endtask

    task automatic t_fp;
        @(negedge clk); f_present = 1;
        @(negedge clk);
        rd(12'h30C); check("R8 mach bit1", rdata, 64'hC000_0000_0000_0001);
        rd(12'h10C); check("R8 sup bit1", rdata, 64'h1);
        @(negedge clk); f_present = 0;
        rd(12'h30C); check("R8 stays clear", rdata, 64'hC000_0000_0000_0001);
    endtask

    task automatic t_illegal;
        rd(12'h31C); check("R10 flag", {63'h0, illegal}, 1);
        check("R10 data", rdata, 0);
        wr(12'h31C, 64'h0);
        rd(12'h30C); check("R10 no write", rdata, 64'hC000_0000_0000_0001);
        rd(12'h30B); check("R10 out of range", {63'h0, illegal}, 0);
        rd(12'h30C); check("R10 legal", {63'h0, illegal}, 0);
    endtask

    task automatic t_narrow;
        wr(12'h30C, 64'hFFFF_FFFF);
        wr(12'h31C, 64'hFFFF_FFFF);
        rd(12'h30C); check("R2 lo half", {32'h0, rdata32}, 64'h3);
        rd(12'h31C); check("R2 hi half", {32'h0, rdata32}, 64'hC000_0000);
        check("R2 hi legal", {63'h0, illegal32}, 0);
        wr(12'h61C, 64'hFFFF_FFFF);
        rd(12'h61C); check("R2 hyp hi", {32'h0, rdata32}, 64'hC000_0000);
        check("R2 m_eff32", m32[63:0], ALL4);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1;
                t_reset();
                t_map_and_mask();
                t_chain();
                t_virt();
                t_fp();
                t_illegal();
                t_narrow();
                @(negedge clk); csr_en = 0;
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule